// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer with Forwarded Clock

The block takes a 21-bit parallel word once per parallel period. It sends that word as three serial data lanes of seven bit slots each. A fourth lane carries a framing clock, so a receiver can find the slot boundaries.

The block does not multiply the clock itself. It runs on a bit clock at seven times the parallel rate. A frame marker input is high for one bit-clock cycle at each parallel rising edge, and that cycle is slot 0 of the frame.

An active-low power-down input disables every output. The outputs come back only after a lock-wait interval. That interval is counted in parallel periods and stands in for the settling time of an external multiplying PLL. A per-bit "input open" flag from the pad detectors marks floating inputs, and each marked bit is sent as a steady high.

Top module: `tri_lane_serializer`

## Requirements
- R1: The word is captured only on a bit-clock edge where `frame_mark` is 1. Changes of `din` in other cycles have no effect on what is sent.
- R2: Lane k carries word bits 7k..7k+6. Bit 7k goes in slot 0 and the rest follow in ascending order, one slot per bit-clock cycle.
- R3: A word captured at one frame marker appears on the lanes in the frame loaded at the following marker. Slot 0 is visible in the bit-clock cycle after that following marker edge.
- R4: `fclk_dat` repeats the slot pattern 1,1,0,0,0,1,1 (slot 0 first) every frame.
- R5: Consecutive words are sent in consecutive frames with no idle slot between them.
- R6: When `pd_n` is sampled low, all four bits of `out_en` are 0 from the next bit-clock cycle on.
- R7: After reset release or a rise of `pd_n`, `out_en` stays 0 until LOCK_CYCLES frame markers have been sampled with `pd_n` high. It becomes all ones after the LOCK_CYCLES-th such marker edge. All four enable bits always share one value.
- R8: `out_en` only turns on at a frame-marker edge, so the first enabled frame is complete.
- R9: A word bit whose `din_open` flag is 1 at capture is sent as 1, whatever `din` holds.
- R10: While `rst_n` is low, all outputs are disabled (`out_en` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the parallel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_mark | input | 1 | High for one bit-clock cycle per parallel period (slot 0) |
| din | input | 21 | Parallel data word |
| din_open | input | 21 | Per-bit floating-input flag; 1 forces the bit high |
| pd_n | input | 1 | Active-low power-down |
| lane_dat | output | 3 | Serial data lane bits |
| fclk_dat | output | 1 | Forwarded framing clock lane bit |
| out_en | output | 4 | Output enables; bits 0..2 for the data lanes, bit 3 for the clock lane |

## Verification
The hardest case to reach from the ports is the handover around power-down release. The word held during the lock wait must go out as the first enabled frame, and the enable must rise exactly at a marker edge. The stimulus drops `pd_n` in the middle of a frame. It keeps sending words through the whole wait and compares every slot of the first frames after re-enable against a bench model of capture and latency. Between markers, `din` carries random junk, which exposes any capture outside slot 0.

// File: rtl/ser_pkg.sv
// Package: shared constants for the three-lane serializer.
// Assumes a 7-slot frame; the clock-lane pattern is indexed by slot number.
package ser_pkg;
    localparam int SER_LANES = 3;
    localparam int SER_SLOTS = 7;
    // bit s = value of the clock lane in slot s (slot 0 first: 1,1,0,0,0,1,1)
    localparam logic [SER_SLOTS-1:0] FCLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/ser_word_capture.sv
// Module: holds the parallel word captured at each frame marker.
// Bits flagged open are replaced by 1 (fail-safe high). Assumes frame_mark
// is high for exactly one bit-clock cycle per parallel period.
module ser_word_capture #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] din_open,
    output logic [WIDTH-1:0] held
);
    logic [WIDTH-1:0] safe_word;

    // Force flagged-open bits high before they enter the hold register.
    always_comb begin
        safe_word = din | din_open;
    end

    // Capture the fail-safe word only on marker cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (capture) begin
            held <= safe_word;
        end
    end
endmodule

// File: rtl/ser_lane_shift.sv
// Module: one serial lane; loads SLOTS bits at the frame marker and sends
// bit 0 first, shifting right once per bit clock. Assumes a new load comes
// every SLOTS cycles; the vacated positions fill with 1.
module ser_lane_shift #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] par,
    output logic             ser
);
    logic [SLOTS-1:0] sreg;

    // Load a new frame at the marker, otherwise advance one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= par;
        end else begin
            sreg <= {1'b1, sreg[SLOTS-1:1]};
        end
    end

    // The current slot is always the low bit.
    always_comb begin
        ser = sreg[0];
    end
endmodule

// File: rtl/ser_power_seq.sv
// Module: power-down and lock-wait sequencer. Counts frame markers seen with
// pd_n high; the outputs are enabled at the LOCK_CYCLES-th such marker.
// A low pd_n clears the count and the enable at the next edge.
module ser_power_seq #(
    parameter int LOCK_CYCLES = 750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_mark,
    input  logic pd_n,
    output logic locked
);
    localparam int CW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Advance the lock-wait count on markers and raise locked at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (frame_mark && !locked) begin
            if (cnt == LAST) begin
                locked <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tri_lane_serializer.sv
// Module: top of the three-lane 7:1 serializer with forwarded clock lane.
// The bit clock and the frame marker come from an external multiplying PLL.
// Latency: a word captured at marker n is sent in the frame loaded at marker n+1.
module tri_lane_serializer
    import ser_pkg::*;
#(
    parameter int LANES       = SER_LANES,
    parameter int SLOTS       = SER_SLOTS,
    parameter int LOCK_CYCLES = 750000
) (
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   frame_mark,
    input  logic [LANES*SLOTS-1:0] din,
    input  logic [LANES*SLOTS-1:0] din_open,
    input  logic                   pd_n,
    output logic [LANES-1:0]       lane_dat,
    output logic                   fclk_dat,
    output logic [LANES:0]         out_en
);
    localparam int WIDTH = LANES * SLOTS;

    logic [WIDTH-1:0] held;
    logic             locked;

    ser_word_capture #(.WIDTH(WIDTH)) u_cap (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .capture  (frame_mark),
        .din      (din),
        .din_open (din_open),
        .held     (held)
    );

    // One shifter per data lane, each fed its own seven-bit slice.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ser_lane_shift #(.SLOTS(SLOTS)) u_sh (
            .clk   (bit_clk),
            .rst_n (rst_n),
            .load  (frame_mark),
            .par   (held[k*SLOTS +: SLOTS]),
            .ser   (lane_dat[k])
        );
    end

    ser_lane_shift #(.SLOTS(SLOTS)) u_fclk (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .load  (frame_mark),
        .par   (FCLK_PATTERN[SLOTS-1:0]),
        .ser   (fclk_dat)
    );

    ser_power_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_pwr (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .frame_mark (frame_mark),
        .pd_n       (pd_n),
        .locked     (locked)
    );

    // All lane drivers share one enable.
    always_comb begin
        out_en = {(LANES+1){locked}};
    end
endmodule

// File: rtl/tri_lane_serializer_chk.sv
// Checker: temporal properties of the serializer ports, bound to the top.
module tri_lane_serializer_chk #(
    parameter int LANES = 3
) (
    input logic           bit_clk,
    input logic           rst_n,
    input logic           frame_mark,
    input logic           pd_n,
    input logic           fclk_dat,
    input logic [LANES:0] out_en
);
    // R6
    pd_disable_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !pd_n |=> (out_en == '0));

    // R8
    enable_boundary_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(out_en[0]) |-> $past(frame_mark));

    // R4
    fclk_slot0_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_mark |=> fclk_dat);

    // R4
    fclk_slot2_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        ($past(frame_mark, 2) && !$past(frame_mark) && !frame_mark) |=> !fclk_dat);

    // R7
    en_group_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (out_en == '0) || (out_en == '1));

    // R10
    reset_off_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == '0));
endmodule

bind tri_lane_serializer tri_lane_serializer_chk #(.LANES(LANES)) u_chk (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .frame_mark (frame_mark),
    .pd_n       (pd_n),
    .fclk_dat   (fclk_dat),
    .out_en     (out_en)
);

// File: tb/sim_tri_lane_serializer.sv
// Bench: random and directed frames, compared slot by slot with a bench model.
module sim_tri_lane_serializer;
    localparam int L    = 5;
    localparam int LN   = 3;
    localparam int SL   = 7;
    localparam int W    = LN * SL;

    logic          bit_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_mark = 1'b0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  din_open = '0;
    logic          pd_n = 1'b1;
    logic [LN-1:0] lane_dat;
    logic          fclk_dat;
    logic [LN:0]   out_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    bit           m_locked = 0;
    int           m_cnt = 0;
    logic [W-1:0] m_hold = '0;
    logic [W-1:0] m_frame = '0;
    int           m_slot = SL;
    string        oe_tag = "R10";
    string        dat_tag = "R2";

    tri_lane_serializer #(.LOCK_CYCLES(L)) u0 (
        .bit_clk(bit_clk), .rst_n(rst_n), .frame_mark(frame_mark),
        .din(din), .din_open(din_open), .pd_n(pd_n),
        .lane_dat(lane_dat), .fclk_dat(fclk_dat), .out_en(out_en)
    );

    always #4 bit_clk = ~bit_clk;

    function automatic logic fclk_ref(input int s);
        return (s <= 1) || (s >= 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bit clock with the given inputs; model update and compare at the negedge.
    task automatic cycle(input logic fs, input logic [W-1:0] d, input logic [W-1:0] op);
        bit prev_locked;
        frame_mark = fs; din = d; din_open = op;
        @(posedge bit_clk);
        @(negedge bit_clk);
        prev_locked = m_locked;
        if (!rst_n) begin
            m_locked = 0; m_cnt = 0; m_hold = '0; m_frame = '0; m_slot = SL;
        end else begin
            if (fs) begin
                m_frame = m_hold; m_hold = d | op; m_slot = 0;
            end else if (m_slot < SL) begin
                m_slot++;
            end
            if (!pd_n) begin
                m_locked = 0; m_cnt = 0;
            end else if (fs && !m_locked) begin
                if (m_cnt == L - 1) m_locked = 1;
                else m_cnt++;
            end
        end
        chk(oe_tag, 32'(out_en), m_locked ? 32'hF : 32'h0);
        if (m_locked && !prev_locked) chk("R8", {31'b0, fs}, 32'd1);
        if (m_locked && m_slot < SL) begin
            for (int k = 0; k < LN; k++)
                chk(dat_tag, {31'b0, lane_dat[k]}, {31'b0, m_frame[k*SL + m_slot]});
            chk("R4", {31'b0, fclk_dat}, {31'b0, fclk_ref(m_slot)});
        end
    endtask

    // One frame: the word at slot 0, junk or the same word in the other slots.
    task automatic frame(input logic [W-1:0] w, input logic [W-1:0] op, input bit junk);
        for (int s = 0; s < SL; s++) begin
            cycle(s == 0, (s == 0 || !junk) ? w : W'($urandom), op);
        end
    endtask

    initial begin
        void'($urandom(32'd20240));
        rst_n = 1'b0;
        oe_tag = "R10";
        for (int i = 0; i < 4; i++) cycle(i == 1, W'($urandom), '0);
        rst_n = 1'b1;
        // lock wait after reset
        oe_tag = "R7";
        dat_tag = "R2";
        for (int f = 0; f < L + 2; f++) frame(W'($urandom), '0, 1'b0);
        // random words
        for (int f = 0; f < 30; f++) frame(W'($urandom), '0, 1'b0);
        // junk between markers must not be captured
        dat_tag = "R1";
        for (int f = 0; f < 20; f++) frame(W'($urandom), '0, 1'b1);
        // walking one: order and latency
        dat_tag = "R3";
        for (int b = 0; b < W; b++) frame(W'(1) << b, '0, 1'b1);
        frame('0, '0, 1'b0);
        // back-to-back extremes, no idle slots
        dat_tag = "R5";
        for (int f = 0; f < 8; f++) frame((f % 2) ? '1 : '0, '0, 1'b0);
        // power-down dropped mid-frame
        oe_tag = "R6";
        dat_tag = "R2";
        cycle(1'b1, W'($urandom), '0);
        cycle(1'b0, W'($urandom), '0);
        pd_n = 1'b0;
        for (int s = 2; s < SL; s++) cycle(1'b0, W'($urandom), '0);
        for (int f = 0; f < 4; f++) frame(W'($urandom), '0, 1'b1);
        pd_n = 1'b1;
        oe_tag = "R7";
        for (int f = 0; f < L + 6; f++) frame(W'($urandom), '0, 1'b1);
        // fail-safe: all inputs flagged open
        dat_tag = "R9";
        for (int f = 0; f < 6; f++) frame('0, '1, 1'b1);
        for (int f = 0; f < 6; f++) frame(W'($urandom), W'($urandom), 1'b1);
        dat_tag = "R2";
        for (int f = 0; f < 3; f++) frame(W'($urandom), '0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule